// File: doc/BRIEF.md
# Streaming Oriented-Kernel Convolution Binarizer

This block turns a grayscale image held in an external memory into a binary ridge map. After a signed square kernel has been loaded through the coefficient port, a start pulse makes the block walk the image one output row at a time. For each interior row it fetches the source image one vertical strip of eleven pixels at a time, pushes that strip into the right-hand side of an eleven-by-eleven two-dimensional shift register, and, once the register holds a full window, multiplies every window pixel by its kernel weight and sums the products. The sign of the sum decides the output pixel: a strictly negative sum is a ridge (1, black), and a zero or positive sum is a valley (0, white).

Pixels whose centre lies within five pixels of any image edge are not convolved and are written as 0. Every output pixel is written exactly once, in row-major order, and a single-cycle done pulse follows the last write. The sequence is run by one state machine with states IDLE (waiting for start), ROW (set up a new output row), FILL (write border zeros), READ (issue the eleven strip reads), LAST (take the final strip pixel and shift the window left), CONV (register the window sum), EMIT (write the sign decision) and DONE (one-cycle completion). Transitions: IDLE to ROW on start; ROW to FILL; FILL to READ when the left border of an interior row is written, to ROW at the end of a row, to DONE at the end of the last row; READ to LAST after the eleventh read; LAST to READ while the window is still filling, otherwise to CONV; CONV to EMIT; EMIT to READ for the next column, or to FILL for the right border; DONE to IDLE.

Top module: `gabor_binarizer`

## Requirements
- R1: A coefficient write with coef_we high stores coef_data (8-bit two's complement) at index coef_idx = i*11 + j, where i is the window row counted from the top (0..10) and j the window column counted from the left (0..10).
- R2: Source reads use rd_addr = y*IMG_W + x (row-major), the memory returns rd_data one clock after rd_en, and every read address lies inside the image.
- R3: For a pixel (r, c) at least five pixels from every edge, the written bit is 1 exactly when the sum over i, j of pixel(r-5+i, c-5+j) times coefficient(i*11+j) is negative, with pixels 8-bit unsigned and the sum computed without overflow even for 255 times -128 in all 121 taps.
- R4: A sum of exactly zero is written as 0, as is any positive sum.
- R5: A pixel whose row or column lies within five pixels of an image edge is written as 0.
- R6: During one run every image address r*IMG_W + c is written exactly once through wr_en/wr_addr, and no address outside the image is written.
- R7: done is high for exactly one clock, in the clock directly after the last output write.
- R8: A start pulse while a run is in progress has no effect: the run still writes each pixel once with correct values and gives one done pulse.
- R9: After reset, rd_en, wr_en and done are low until start is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| coef_we | input | 1 | Kernel weight write strobe |
| coef_idx | input | 7 | Kernel weight index, row*11 + column |
| coef_data | input | 8 | Kernel weight, two's complement |
| start | input | 1 | Begin one image pass (ignored while busy) |
| rd_en | output | 1 | Source memory read request |
| rd_addr | output | 8 | Source pixel address, row-major |
| rd_data | input | 8 | Source pixel, valid one clock after rd_en |
| wr_en | output | 1 | Binary pixel write strobe |
| wr_addr | output | 8 | Binary pixel address, row-major |
| wr_bit | output | 1 | Binary pixel value, 1 = ridge |
| done | output | 1 | One-clock completion pulse |

## Verification
The assertions take for granted that the source memory answers with exactly one clock of read latency and keeps its contents stable during a pass, and that the kernel is loaded only while the block is idle; the bench memory model is a registered read of a static array and the kernel loads happen strictly between runs. They also assume the image is at least as wide and tall as the window, which the default geometry satisfies. Stimulus mixes directed kernels (all zero, uniform negative, extreme magnitude, cancelling pairs that give an exact zero sum) with seeded random kernels and images, plus one run with a second start pulse mid-pass.

// File: rtl/gbz_pkg.sv
package gbz_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ROW,
        ST_FILL,
        ST_READ,
        ST_LAST,
        ST_CONV,
        ST_EMIT,
        ST_DONE
    } gbz_state_t;

endpackage

// File: rtl/gbz_coef_bank.sv
module gbz_coef_bank #(
    parameter int K      = 11,
    parameter int COEF_W = 8,
    localparam int KK    = K * K,
    localparam int IDX_W = $clog2(KK)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we_i,
    input  logic [IDX_W-1:0]         idx_i,
    input  logic signed [COEF_W-1:0] data_i,
    output logic signed [COEF_W-1:0] coef_o [KK]
);

    // one register per tap, written by index
    for (genvar n = 0; n < KK; n++) begin : g_tap
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                coef_o[n] <= '0;
            end else if (we_i && (int'(idx_i) == n)) begin
                coef_o[n] <= data_i;
            end
        end
    end

endmodule

// File: rtl/gbz_window.sv
module gbz_window #(
    parameter int K     = 11,
    parameter int PIX_W = 8,
    localparam int KK   = K * K,
    localparam int KW   = $clog2(K + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en_i,
    input  logic [KW-1:0]    cap_idx_i,
    input  logic [PIX_W-1:0] pix_i,
    input  logic             shift_i,
    output logic [PIX_W-1:0] win_o [KK]
);

    logic [PIX_W-1:0] strip_q [K];
    logic [PIX_W-1:0] strip_in [K];

    // strip buffer: captured pixels of the column being fetched
    for (genvar i = 0; i < K; i++) begin : g_strip
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                strip_q[i] <= '0;
            end else if (cap_en_i && (int'(cap_idx_i) == i)) begin
                strip_q[i] <= pix_i;
            end
        end
        // the bottom pixel arrives in the shift cycle itself
        if (i == K - 1) begin : g_bottom
            assign strip_in[i] = pix_i;
        end else begin : g_upper
            assign strip_in[i] = strip_q[i];
        end
    end

    // 2-D shift register, index = row*K + col, col 0 is the oldest column
    for (genvar i = 0; i < K; i++) begin : g_row
        for (genvar j = 0; j < K; j++) begin : g_col
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    win_o[i*K + j] <= '0;
                end else if (shift_i) begin
                    if (j == K - 1) begin
                        win_o[i*K + j] <= strip_in[i];
                    end else begin
                        win_o[i*K + j] <= win_o[i*K + j + 1];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/gbz_mac.sv
module gbz_mac #(
    parameter int K      = 11,
    parameter int PIX_W  = 8,
    parameter int COEF_W = 8,
    localparam int KK    = K * K,
    localparam int PW    = PIX_W + COEF_W + 1,
    localparam int ACC_W = PW + $clog2(KK)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     calc_i,
    input  logic [PIX_W-1:0]         win_i  [KK],
    input  logic signed [COEF_W-1:0] coef_i [KK],
    output logic signed [ACC_W-1:0]  sum_o
);

    logic signed [ACC_W-1:0] acc;

    always_comb begin
        logic signed [PW-1:0] prod;
        acc = '0;
        for (int n = 0; n < KK; n++) begin
            prod = PW'($signed({1'b0, win_i[n]})) * PW'(coef_i[n]);
            acc  = acc + ACC_W'(prod);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_o <= '0;
        end else if (calc_i) begin
            sum_o <= acc;
        end
    end

endmodule

// File: rtl/gbz_sequencer.sv
module gbz_sequencer
    import gbz_pkg::*;
#(
    parameter int IMG_W = 16,
    parameter int IMG_H = 16,
    parameter int K     = 11,
    localparam int HALF = K / 2,
    localparam int AW   = $clog2(IMG_W * IMG_H),
    localparam int RW   = $clog2(IMG_H),
    localparam int CW   = $clog2(IMG_W + 1),
    localparam int KW   = $clog2(K + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output logic          rd_en_o,
    output logic [AW-1:0] rd_addr_o,
    output logic          cap_en_o,
    output logic [KW-1:0] cap_idx_o,
    output logic          shift_o,
    output logic          calc_o,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic          emit_o,
    output logic          done_o
);

    gbz_state_t state_q, state_d;

    logic [RW-1:0] row_q;
    logic [CW-1:0] x_q;
    logic [CW-1:0] out_col_q;
    logic [CW-1:0] fill_end_q;
    logic [KW-1:0] k_q;
    logic          row_inner;
    logic          fill_last;
    logic          row_final;
    logic          strip_last;
    logic          window_full;
    logic          col_final;

    assign row_inner   = (int'(row_q) >= HALF) && (int'(row_q) < IMG_H - HALF);
    assign fill_last   = (int'(out_col_q) == int'(fill_end_q) - 1);
    assign row_final   = (int'(row_q) == IMG_H - 1);
    assign strip_last  = (int'(k_q) == K - 1);
    assign window_full = (int'(x_q) >= K - 1);
    assign col_final   = (int'(x_q) == IMG_W - 1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_ROW;
            ST_ROW:  state_d = ST_FILL;
            ST_FILL: begin
                if (fill_last) begin
                    if (int'(out_col_q) == IMG_W - 1) begin
                        state_d = row_final ? ST_DONE : ST_ROW;
                    end else begin
                        state_d = ST_READ;
                    end
                end
            end
            ST_READ: if (strip_last) state_d = ST_LAST;
            ST_LAST: state_d = window_full ? ST_CONV : ST_READ;
            ST_CONV: state_d = ST_EMIT;
            ST_EMIT: state_d = col_final ? ST_FILL : ST_READ;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q      <= '0;
            x_q        <= '0;
            out_col_q  <= '0;
            fill_end_q <= '0;
            k_q        <= '0;
            cap_en_o   <= 1'b0;
            cap_idx_o  <= '0;
        end else begin
            cap_en_o  <= (state_q == ST_READ);
            cap_idx_o <= k_q;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) row_q <= '0;
                    k_q <= '0;
                end
                ST_ROW: begin
                    out_col_q  <= '0;
                    x_q        <= '0;
                    k_q        <= '0;
                    fill_end_q <= row_inner ? CW'(HALF) : CW'(IMG_W);
                end
                ST_FILL: begin
                    out_col_q <= out_col_q + 1'b1;
                    if (fill_last && (int'(out_col_q) == IMG_W - 1) && !row_final) begin
                        row_q <= row_q + 1'b1;
                    end
                end
                ST_READ: k_q <= k_q + 1'b1;
                ST_LAST: begin
                    k_q <= '0;
                    if (!window_full) x_q <= x_q + 1'b1;
                end
                ST_CONV: ;
                ST_EMIT: begin
                    out_col_q <= out_col_q + 1'b1;
                    if (col_final) begin
                        fill_end_q <= CW'(IMG_W);
                    end else begin
                        x_q <= x_q + 1'b1;
                    end
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        int src;
        src       = (int'(row_q) + int'(k_q) - HALF) * IMG_W + int'(x_q);
        rd_addr_o = AW'(src);
        wr_addr_o = AW'(int'(row_q) * IMG_W + int'(out_col_q));
        rd_en_o   = (state_q == ST_READ);
        shift_o   = (state_q == ST_LAST);
        calc_o    = (state_q == ST_CONV);
        emit_o    = (state_q == ST_EMIT);
        wr_en_o   = (state_q == ST_FILL) || (state_q == ST_EMIT);
        done_o    = (state_q == ST_DONE);
    end

endmodule

// File: rtl/gabor_binarizer.sv
module gabor_binarizer #(
    parameter int IMG_W  = 16,
    parameter int IMG_H  = 16,
    parameter int K      = 11,
    parameter int PIX_W  = 8,
    parameter int COEF_W = 8,
    localparam int KK    = K * K,
    localparam int HALF  = K / 2,
    localparam int AW    = $clog2(IMG_W * IMG_H),
    localparam int IDX_W = $clog2(KK),
    localparam int KW    = $clog2(K + 1),
    localparam int ACC_W = PIX_W + COEF_W + 1 + $clog2(KK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              coef_we,
    input  logic [IDX_W-1:0]  coef_idx,
    input  logic [COEF_W-1:0] coef_data,
    input  logic              start,
    output logic              rd_en,
    output logic [AW-1:0]     rd_addr,
    input  logic [PIX_W-1:0]  rd_data,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic              wr_bit,
    output logic              done
);

    logic signed [COEF_W-1:0] coef [KK];
    logic [PIX_W-1:0]         win  [KK];
    logic signed [ACC_W-1:0]  sum_q;
    logic                     cap_en;
    logic [KW-1:0]            cap_idx;
    logic                     shift;
    logic                     calc;
    logic                     emit;

    gbz_coef_bank #(.K(K), .COEF_W(COEF_W)) u_coef (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (coef_we),
        .idx_i  (coef_idx),
        .data_i (coef_data),
        .coef_o (coef)
    );

    gbz_sequencer #(.IMG_W(IMG_W), .IMG_H(IMG_H), .K(K)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .rd_en_o   (rd_en),
        .rd_addr_o (rd_addr),
        .cap_en_o  (cap_en),
        .cap_idx_o (cap_idx),
        .shift_o   (shift),
        .calc_o    (calc),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .emit_o    (emit),
        .done_o    (done)
    );

    gbz_window #(.K(K), .PIX_W(PIX_W)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en_i  (cap_en),
        .cap_idx_i (cap_idx),
        .pix_i     (rd_data),
        .shift_i   (shift),
        .win_o     (win)
    );

    gbz_mac #(.K(K), .PIX_W(PIX_W), .COEF_W(COEF_W)) u_mac (
        .clk    (clk),
        .rst_n  (rst_n),
        .calc_i (calc),
        .win_i  (win),
        .coef_i (coef),
        .sum_o  (sum_q)
    );

    // strictly negative sum is ridge; zero and positive are valley
    assign wr_bit = emit && sum_q[ACC_W-1];

    // border position of the current write, decoded from the address
    logic on_border;
    always_comb begin
        int wr_r;
        int wr_c;
        wr_r = int'(wr_addr) / IMG_W;
        wr_c = int'(wr_addr) % IMG_W;
        on_border = (wr_r < HALF) || (wr_r >= IMG_H - HALF) ||
                    (wr_c < HALF) || (wr_c >= IMG_W - HALF);
    end

    assert_rd_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (int'(rd_addr) < IMG_W * IMG_H));

    assert_border_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && on_border) |-> !wr_bit);

    assert_wr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_addr) < IMG_W * IMG_H));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(wr_en) && !wr_en));

endmodule

// File: tb/tb_gabor_binarizer.sv
module tb_gabor_binarizer;

    localparam int CLK_PERIOD = 10;
    localparam int W     = 16;
    localparam int H     = 16;
    localparam int K     = 11;
    localparam int HALF  = K / 2;
    localparam int NPIX  = W * H;
    localparam int LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       coef_we = 1'b0;
    logic [6:0] coef_idx = '0;
    logic [7:0] coef_data = '0;
    logic       start = 1'b0;
    logic       rd_en;
    logic [7:0] rd_addr;
    logic [7:0] rd_data = '0;
    logic       wr_en;
    logic [7:0] wr_addr;
    logic       wr_bit;
    logic       done;

    logic [7:0] img  [NPIX];
    int         cf   [K*K];
    int         hits [NPIX];
    logic       outb [NPIX];
    int         cyc = 0;
    int         last_wr = 0;
    int         done_cyc = 0;
    int         done_cnt = 0;
    int         total = 0;
    int         bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gabor_binarizer dut (
        .clk(clk), .rst_n(rst_n), .coef_we(coef_we), .coef_idx(coef_idx),
        .coef_data(coef_data), .start(start), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_bit(wr_bit),
        .done(done)
    );

    // source memory, one clock read latency (R2)
    always @(posedge clk) begin
        if (rd_en) rd_data <= img[int'(rd_addr) % NPIX];
    end

    // output monitor away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (wr_en) begin
            if (int'(wr_addr) < NPIX) begin
                hits[wr_addr]++;
                outb[wr_addr] = wr_bit;
            end else begin
                hits[0] += 1000;
            end
            last_wr = cyc;
        end
        if (done) begin
            done_cnt++;
            done_cyc = cyc;
        end
        if (cyc > LIMIT) begin
            total++; bad++;
            $display("FAIL watchdog: actual cycles=%0d expected<=%0d", cyc, LIMIT);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_bit(input int r, input int c);
        int s;
        if (r < HALF || r >= H - HALF || c < HALF || c >= W - HALF) return 0;
        s = 0;
        for (int i = 0; i < K; i++)
            for (int j = 0; j < K; j++)
                s += int'(img[(r - HALF + i) * W + (c - HALF + j)]) * cf[i*K + j];
        return (s < 0) ? 1 : 0;
    endfunction

    task automatic load_coefs();
        for (int n = 0; n < K*K; n++) begin
            @(negedge clk);
            coef_we   = 1'b1;
            coef_idx  = 7'(n);
            coef_data = 8'(cf[n]);
        end
        @(negedge clk);
        coef_we = 1'b0;
    endtask

    task automatic run_pass(input string tag, input bit restart);
        for (int a = 0; a < NPIX; a++) begin
            hits[a] = 0;
            outb[a] = 1'b0;
        end
        done_cnt = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (restart) begin
            repeat (300) @(negedge clk);
            start = 1'b1;     // R8: must be ignored mid-pass
            @(negedge clk);
            start = 1'b0;
        end
        while (done_cnt == 0) @(negedge clk);
        repeat (5) @(negedge clk);
        check({tag, " R7 single done"}, done_cnt, 1);
        check({tag, " R7 done follows last write"}, done_cyc - last_wr, 1);
        if (restart) check({tag, " R8 pass unaffected by start"}, done_cnt, 1);
        for (int r = 0; r < H; r++) begin
            for (int c = 0; c < W; c++) begin
                int a;
                a = r * W + c;
                check({tag, " R6 written once"}, hits[a], 1);
                if (r < HALF || r >= H - HALF || c < HALF || c >= W - HALF)
                    check({tag, " R5 border zero"}, int'(outb[a]), 0);
                else
                    check({tag, " R3/R4 sign decision"}, int'(outb[a]), ref_bit(r, c));
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int a = 0; a < NPIX; a++) img[a] = 8'($urandom_range(0, 255));
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 rd_en at reset", int'(rd_en), 0);
        check("R9 wr_en at reset", int'(wr_en), 0);
        check("R9 done at reset", int'(done), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R9 idle before start", int'(rd_en | wr_en | done), 0);

        // R4: all-zero kernel gives zero sums, written as valley
        for (int n = 0; n < K*K; n++) cf[n] = 0;
        load_coefs();
        run_pass("zero kernel", 1'b0);

        // R3: uniform negative kernel
        for (int n = 0; n < K*K; n++) cf[n] = -1;
        load_coefs();
        for (int a = 0; a < NPIX; a++) img[a] = 8'($urandom_range(1, 255));
        run_pass("negative kernel", 1'b0);

        // R3: extreme magnitude, no overflow either way
        for (int a = 0; a < NPIX; a++) img[a] = 8'd255;
        for (int n = 0; n < K*K; n++) cf[n] = -128;
        load_coefs();
        run_pass("max negative", 1'b0);
        for (int n = 0; n < K*K; n++) cf[n] = 127;
        load_coefs();
        run_pass("max positive", 1'b0);

        // R4: cancelling pair on a flat image gives an exact zero sum
        for (int a = 0; a < NPIX; a++) img[a] = 8'd77;
        for (int n = 0; n < K*K; n++) cf[n] = 0;
        cf[3] = 5; cf[90] = -5;
        load_coefs();
        run_pass("exact zero", 1'b0);

        // R1: single tap, position decides which pixel drives the result
        for (int a = 0; a < NPIX; a++) img[a] = ($urandom_range(0, 1) != 0) ? 8'd9 : 8'd0;
        for (int n = 0; n < K*K; n++) cf[n] = 0;
        cf[2*K + 7] = -3;
        load_coefs();
        run_pass("R1 single tap", 1'b0);

        // R1/R2/R3: seeded random kernels and images
        for (int t = 0; t < 4; t++) begin
            for (int a = 0; a < NPIX; a++) img[a] = 8'($urandom_range(0, 255));
            for (int n = 0; n < K*K; n++) cf[n] = int'($urandom_range(0, 255)) - 128;
            load_coefs();
            run_pass("random", (t == 2));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule